// File: doc/BRIEF.md
# Floating-Point Compare Condition-Code Unit

This unit compares two IEEE-754 operands, A and B, in either single or double precision. It writes the ordering of A relative to B as a two-bit condition code into one of four code fields of a 32-bit floating-point status register, which the unit holds internally.

A comparison is unordered when either operand is a NaN. In that case the unit writes the unordered code and then takes one of two paths, chosen by an invalid-operation trap mask input. With the mask set, it raises a one-cycle trap request. With the mask clear, it sets a sticky invalid-accrued bit in the status register.

A caller drives the operands, the precision select, the field select and the mask together with a one-cycle start strobe. The updated register and a done pulse appear after the next clock edge.

Top module: `fp_cmp_cc_unit`

## Requirements
- R1: While rst_ni is low, and after it is released, status_o, done_o and trap_o are all zero.
- R2: A comparison is sampled at a rising edge with start_i high. After that edge, done_o is high for exactly one cycle. When start_i is low at an edge, status_o keeps its value whatever the other inputs carry.
- R3: For ordered operands the code is 2'b01 when A < B, 2'b10 when A > B and 2'b00 when A == B.
- R4: The fld_sel_i value picks the field written: 0 picks bits [1:0], 1 picks bits [23:22], 2 picks bits [25:24] and 3 picks bits [27:26]. No other bit changes, except the invalid-accrued bit (bit 5).
- R5: Both bits of the selected field are replaced, so a field holding 2'b11 reads back exactly as the new code.
- R6: An operand is a NaN when its exponent is all ones and its mantissa is nonzero. Any NaN operand gives the code 2'b11. An infinity is not a NaN.
- R7: An unordered result with trap_mask_i low sets bit 5 of the status register and raises no trap. Bit 5 stays set afterwards until reset.
- R8: An unordered result with trap_mask_i high writes 2'b11 and pulses trap_o together with done_o. Bit 5 is left unchanged.
- R9: Positive zero and negative zero compare equal (2'b00).
- R10: When both operands are negative, the one with the larger magnitude is the smaller.
- R11: With dbl_i low, only bits [31:0] of each operand are used (1-bit sign, 8-bit exponent, 23-bit mantissa) and bits [63:32] have no effect. With dbl_i high, all 64 bits are used (1-bit sign, 11-bit exponent, 52-bit mantissa).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe; samples all other inputs |
| dbl_i | input | 1 | 1 = double precision, 0 = single precision |
| fld_sel_i | input | 2 | Selects the condition-code field to write |
| trap_mask_i | input | 1 | Invalid-operation trap enable |
| op_a_i | input | 64 | Operand A |
| op_b_i | input | 64 | Operand B |
| status_o | output | 32 | Status register |
| done_o | output | 1 | Result-written pulse |
| trap_o | output | 1 | Invalid-operation trap request pulse |

## Verification
The in-RTL assertions check the following on every cycle:
- the register holds its value without a start strobe;
- done is a single pulse;
- bits outside the chosen field and the accrued bit never move;
- the accrued bit never clears;
- a trap always leaves 2'b11 in the chosen field and leaves the accrued bit as it was.

Some behaviours can only be shown by the bench's scenarios, which compare results against an independent key-ordering model. These are:
- the actual ordering codes, including signed zeros, negative-operand reversal and NaN versus infinity;
- that a single-precision compare ignores the upper operand halves;
- the choice between trapping and accruing.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
  typedef enum logic [1:0] {
    REL_EQ = 2'b00,
    REL_LT = 2'b01,
    REL_GT = 2'b10,
    REL_UN = 2'b11
  } rel_e;

  localparam int unsigned MAG_W = 63;

  typedef struct packed {
    logic             nan;
    logic             zero;
    logic             sign;
    logic [MAG_W-1:0] mag;
  } opnd_t;

  // field offsets are fixed by consumers of the status word
  function automatic int unsigned fld_ofs(input logic [1:0] sel);
    case (sel)
      2'd0:    return 0;
      2'd1:    return 22;
      2'd2:    return 24;
      default: return 26;
    endcase
  endfunction

  function automatic logic [31:0] fld_mask(input logic [1:0] sel);
    return 32'h3 << fld_ofs(sel);
  endfunction
endpackage

// File: rtl/fcc_classify.sv
module fcc_classify
  import fcc_pkg::*;
#(
  parameter int unsigned S_EXP = 8,
  parameter int unsigned S_MAN = 23,
  parameter int unsigned D_EXP = 11,
  parameter int unsigned D_MAN = 52
) (
  input  logic [D_EXP+D_MAN:0] op_i,
  input  logic                 dbl_i,
  output opnd_t                cls_o
);
  localparam int unsigned SW = 1 + S_EXP + S_MAN;
  localparam int unsigned DW = 1 + D_EXP + D_MAN;

  logic [S_EXP-1:0] s_exp;
  logic [S_MAN-1:0] s_man;
  logic [D_EXP-1:0] d_exp;
  logic [D_MAN-1:0] d_man;

  assign s_exp = op_i[SW-2 -: S_EXP];
  assign s_man = op_i[S_MAN-1:0];
  assign d_exp = op_i[DW-2 -: D_EXP];
  assign d_man = op_i[D_MAN-1:0];

  always_comb begin
    if (dbl_i) begin
      cls_o.nan  = (&d_exp) && (|d_man);
      cls_o.zero = ~|op_i[DW-2:0];
      cls_o.sign = op_i[DW-1];
      cls_o.mag  = MAG_W'(op_i[DW-2:0]);
    end else begin
      cls_o.nan  = (&s_exp) && (|s_man);
      cls_o.zero = ~|op_i[SW-2:0];
      cls_o.sign = op_i[SW-1];
      cls_o.mag  = MAG_W'(op_i[SW-2:0]);
    end
  end
endmodule

// File: rtl/fcc_relation.sv
module fcc_relation
  import fcc_pkg::*;
(
  input  opnd_t a_i,
  input  opnd_t b_i,
  output rel_e  rel_o
);
  always_comb begin
    if (a_i.nan || b_i.nan)         rel_o = REL_UN;
    else if (a_i.zero && b_i.zero)  rel_o = REL_EQ;
    else if (a_i.sign != b_i.sign)  rel_o = a_i.sign ? REL_LT : REL_GT;
    else if (a_i.mag == b_i.mag)    rel_o = REL_EQ;
    else if (a_i.mag < b_i.mag)     rel_o = a_i.sign ? REL_GT : REL_LT;
    else                            rel_o = a_i.sign ? REL_LT : REL_GT;
  end
endmodule

// File: rtl/fcc_status_upd.sv
module fcc_status_upd
  import fcc_pkg::*;
#(
  parameter int unsigned STAT_W  = 32,
  parameter int unsigned NVA_BIT = 5
) (
  input  logic [STAT_W-1:0] stat_i,
  input  rel_e              rel_i,
  input  logic [1:0]        sel_i,
  input  logic              trap_mask_i,
  output logic [STAT_W-1:0] stat_o,
  output logic              trap_o
);
  logic [STAT_W-1:0] clr_mask, code_bits;

  assign clr_mask  = STAT_W'(2'b11) << fld_ofs(sel_i);
  assign code_bits = STAT_W'(rel_i) << fld_ofs(sel_i);

  always_comb begin
    stat_o = (stat_i & ~clr_mask) | code_bits;
    trap_o = 1'b0;
    if (rel_i == REL_UN) begin
      if (trap_mask_i) trap_o = 1'b1;
      else             stat_o[NVA_BIT] = 1'b1;
    end
  end
endmodule

// File: rtl/fp_cmp_cc_unit.sv
module fp_cmp_cc_unit
  import fcc_pkg::*;
#(
  parameter int unsigned STAT_W  = 32,
  parameter int unsigned OP_W    = 64,
  parameter int unsigned NVA_BIT = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              dbl_i,
  input  logic [1:0]        fld_sel_i,
  input  logic              trap_mask_i,
  input  logic [OP_W-1:0]   op_a_i,
  input  logic [OP_W-1:0]   op_b_i,
  output logic [STAT_W-1:0] status_o,
  output logic              done_o,
  output logic              trap_o
);
  localparam int unsigned N_OP = 2;

  logic [OP_W-1:0]   ops [N_OP];
  opnd_t             cls [N_OP];
  rel_e              rel;
  logic [STAT_W-1:0] stat_q, stat_n;
  logic              trap_n, done_q, trap_q;

  assign ops[0] = op_a_i;
  assign ops[1] = op_b_i;

  for (genvar g = 0; g < N_OP; g++) begin : g_cls
    fcc_classify u_cls (.op_i(ops[g]), .dbl_i(dbl_i), .cls_o(cls[g]));
  end

  fcc_relation u_rel (.a_i(cls[0]), .b_i(cls[1]), .rel_o(rel));

  fcc_status_upd #(.STAT_W(STAT_W), .NVA_BIT(NVA_BIT)) u_upd (
    .stat_i(stat_q), .rel_i(rel), .sel_i(fld_sel_i),
    .trap_mask_i(trap_mask_i), .stat_o(stat_n), .trap_o(trap_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      done_q <= 1'b0;
      trap_q <= 1'b0;
    end else begin
      done_q <= start_i;
      trap_q <= start_i && trap_n;
      if (start_i) stat_q <= stat_n;
    end
  end

  assign status_o = stat_q;
  assign done_o   = done_q;
  assign trap_o   = trap_q;

  a_r2_hold_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(status_o));

  a_r2_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> !done_o);

  a_r4_other_bits_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (((status_o ^ $past(status_o)) &
                 ~(fld_mask($past(fld_sel_i)) | (32'h1 << NVA_BIT))) == '0));

  a_r7_nva_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(status_o[NVA_BIT]));

  a_r8_trap_code: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (done_o && (((status_o >> fld_ofs($past(fld_sel_i))) & 32'h3) == 32'h3)));

  a_r8_trap_no_accrue: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (status_o[NVA_BIT] == $past(status_o[NVA_BIT])));
endmodule

// File: tb/fp_cmp_cc_unit_tb_top.sv
module fp_cmp_cc_unit_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic        dbl_i = 1'b0;
  logic [1:0]  fld_sel_i = '0;
  logic        trap_mask_i = 1'b0;
  logic [63:0] op_a_i = '0, op_b_i = '0;
  logic [31:0] status_o;
  logic        done_o, trap_o;

  int n_run = 0, n_fail = 0;
  logic [31:0] m_stat = '0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  fp_cmp_cc_unit dut_i (
    .clk_i, .rst_ni, .start_i, .dbl_i, .fld_sel_i, .trap_mask_i,
    .op_a_i, .op_b_i, .status_o, .done_o, .trap_o
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] okey(input logic [63:0] x, input bit dbl);
    logic [63:0] v;
    if (dbl) begin
      if (x[62:0] == 0) return 64'h8000_0000_0000_0000;
      v = x[63] ? ~x : (x ^ 64'h8000_0000_0000_0000);
      return v;
    end
    if (x[30:0] == 0) return 64'h8000_0000;
    v = {32'h0, x[31] ? ~x[31:0] : (x[31:0] ^ 32'h8000_0000)};
    return v;
  endfunction

  function automatic bit is_nan(input logic [63:0] x, input bit dbl);
    if (dbl) return (x[62:52] == 11'h7FF) && (x[51:0] != 0);
    return (x[30:23] == 8'hFF) && (x[22:0] != 0);
  endfunction

  function automatic logic [1:0] exp_code(input logic [63:0] a, input logic [63:0] b, input bit dbl);
    logic [63:0] ka, kb;
    if (is_nan(a, dbl) || is_nan(b, dbl)) return 2'b11;
    ka = okey(a, dbl);
    kb = okey(b, dbl);
    if (ka < kb) return 2'b01;
    if (ka > kb) return 2'b10;
    return 2'b00;
  endfunction

  function automatic int ofs(input logic [1:0] s);
    case (s)
      2'd0: return 0;
      2'd1: return 22;
      2'd2: return 24;
      default: return 26;
    endcase
  endfunction

  task automatic do_cmp(input logic [63:0] a, input logic [63:0] b, input bit dbl,
                        input logic [1:0] sel, input bit mask, input string req);
    logic [1:0]  code;
    logic [31:0] prev;
    bit          etrap;
    @(negedge clk_i);
    op_a_i = a; op_b_i = b; dbl_i = dbl; fld_sel_i = sel; trap_mask_i = mask;
    start_i = 1'b1;
    code  = exp_code(a, b, dbl);
    etrap = (code == 2'b11) && mask;
    m_stat = m_stat & ~(32'h3 << ofs(sel));
    m_stat = m_stat | (32'(code) << ofs(sel));
    if (code == 2'b11 && !mask) m_stat[5] = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(status_o == m_stat, req, 64'(status_o), 64'(m_stat));
    chk(done_o == 1'b1, "R2 done", 64'(done_o), 64'h1);
    chk(trap_o == etrap, etrap ? "R8 trap" : "R7 no trap", 64'(trap_o), 64'(etrap));
    prev = status_o;
    op_a_i = {$urandom, $urandom}; op_b_i = {$urandom, $urandom};
    fld_sel_i = 2'($urandom); trap_mask_i = 1'($urandom);
    @(negedge clk_i);
    chk(done_o == 1'b0, "R2 done pulse", 64'(done_o), 64'h0);
    chk(status_o == prev, "R2 idle hold", 64'(status_o), 64'(prev));
  endtask

  function automatic logic [63:0] pick(input bit dbl);
    logic [63:0] r;
    r = {$urandom, $urandom};
    case ($urandom % 8)
      0: r = dbl ? 64'h7FF8_0000_0000_0001 : {r[63:32], 32'h7FC0_0001};
      1: r = dbl ? {r[63], 63'h0} : {r[63:32], r[31], 31'h0};
      2: r = dbl ? {r[63], 11'h7FF, 52'h0} : {r[63:32], r[31], 8'hFF, 23'h0};
      3: r = dbl ? {r[63], 11'h3FF, r[51:48], 48'h0} : {r[63:32], r[31], 8'h7F, r[22:20], 20'h0};
      default: ;
    endcase
    return r;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    #(CLK_PERIOD * 2);
    // R1 reset state
    chk(status_o == 0 && !done_o && !trap_o, "R1 in reset", 64'(status_o), 64'h0);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i);
    chk(status_o == 0 && !done_o && !trap_o, "R1 after reset", 64'(status_o), 64'h0);

    do_cmp(64'h3F80_0000, 64'h4000_0000, 0, 2'd0, 0, "R3 lt, R4 field0");
    do_cmp(64'h4000_0000, 64'h3F80_0000, 0, 2'd1, 0, "R3 gt, R4 field1");
    do_cmp(64'h4040_0000, 64'h4040_0000, 0, 2'd2, 0, "R3 eq, R4 field2");
    do_cmp(64'h0000_0000, 64'h8000_0000, 0, 2'd3, 0, "R9 zeros, R4 field3");
    do_cmp(64'hBF80_0000, 64'hC000_0000, 0, 2'd3, 0, "R10 neg reversed");
    do_cmp(64'h7F80_0000, 64'h7F80_0000, 0, 2'd0, 0, "R6 inf not nan");
    do_cmp(64'h7FC0_0000, 64'h3F80_0000, 0, 2'd1, 0, "R6 R7 nan accrue");
    do_cmp(64'h3F80_0000, 64'h4000_0000, 0, 2'd1, 0, "R5 field replaced");
    do_cmp(64'h3FF0_0000_0000_0000, 64'h7FF0_0000_0000_0001, 1, 2'd2, 1, "R8 trap dbl");
    do_cmp(64'h3FF0_0000_0000_0000, 64'h4000_0000_0000_0000, 1, 2'd2, 1, "R11 dbl lt, R5");
    do_cmp(64'hFFFF_FFFF_3F80_0000, 64'h0000_0000_4000_0000, 0, 2'd0, 1, "R11 upper ignored");
    do_cmp(64'hBFF0_0000_0000_0000, 64'h8000_0000_0000_0000, 1, 2'd3, 0, "R10 dbl neg vs zero");

    for (int i = 0; i < 400; i++) begin
      automatic bit d = 1'($urandom);
      do_cmp(pick(d), pick(d), d, 2'($urandom), 1'($urandom), "R3 random");
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule